// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine

This block is the column side of a four-bank, 16-bit synchronous DRAM device model. A mode-set strobe with a 12-bit key selects the read latency, the burst length, the burst ordering and whether writes burst or touch only a single location. After that, decoded read, write, precharge and burst-stop strobes, together with a starting column, drive a column sequencer. The sequencer emits one column beat per cycle, and each beat either writes a 256 x 16 row buffer under per-byte masks or feeds a read latency pipeline.

The read pipeline returns each word a programmed number of cycles after its beat. A separate two-cycle delayed copy of the byte masks disables output bytes. Row activation, refresh and electrical behaviour belong to neighbouring blocks. The row buffer exists so that the model can check itself end to end, and it clears on reset.

Top module: `sdram_col_engine`

## Requirements
- R1: After reset no beat, read data or byte enable is active, the row buffer reads zero, and the mode is latency 3, burst length 1, sequential ordering, burst writes.
- R2: A mode key sets burst length from bits [2:0] (000=1, 001=2, 010=4, 011=8, 111=full row), ordering from bit 3 (1=interleaved), latency from bits [6:4] (001..011 = 1..3 cycles) and single-location writes from bit 9. A key with any other length or latency code is ignored as a whole.
- R3: A read or write command presents its starting column as beat 0 on `col_addr` in the command cycle. It then issues one further beat per cycle until the burst length is reached.
- R4: In sequential order, beat k addresses the start column with its low log2(length) bits replaced by (start + k) modulo the length.
- R5: In interleaved order, those low bits are (start XOR k). A full-row burst always runs sequentially, wraps from column 255 to 0, and continues until it is stopped.
- R6: With single-location writes selected, a write issues exactly one beat, while reads still use the programmed burst length.
- R7: On a write beat, a high `byte_mask[1]` (upper byte) or `byte_mask[0]` (lower byte) blocks that byte in the same cycle, and that byte of the stored word keeps its old value.
- R8: Read data for a beat issued in cycle T appears on `rd_data` with `rd_valid` high in cycle T + latency.
- R9: During reads, a mask bit that is high in cycle T drops that byte's `rd_oe` bit in cycle T+2, and the byte reads as zero.
- R10: A precharge or burst stop issues no beat in its own cycle and ends the burst. Read data therefore stops after the last beat that was issued before it.
- R11: A new read or write during a burst replaces it in the same cycle. Data of the old burst that is already in flight still emerges.
- R12: When strobes coincide, precharge and burst stop suppress any column command, and a read takes priority over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_en | input | 1 | Mode set strobe |
| mrs_key | input | 12 | Mode key (R2 field positions) |
| rd_cmd | input | 1 | Read column command |
| wr_cmd | input | 1 | Write column command |
| bst_cmd | input | 1 | Burst stop |
| pre_cmd | input | 1 | Precharge of the open bank |
| col_in | input | 8 | Starting column |
| byte_mask | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| wr_data | input | 16 | Write data for the current beat |
| col_valid | output | 1 | A beat is issued this cycle |
| col_wr | output | 1 | The current beat is a write |
| col_addr | output | 8 | Column of the current beat |
| wr_be | output | 2 | Per-byte write enables |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data, disabled bytes zero |
| rd_oe | output | 2 | Per-byte output enables |

## Verification
The bench walks a table of start columns that sit near burst boundaries in both orderings. A sequencer that carried into the upper column bits, or that added where it should XOR, emits a wrong column at the wrap point. A precharge during a read checks that exactly the earlier beats come out at the programmed latency. A late kill would leak a word, and an early one would lose one. The read-mask test puts the mask two cycles ahead of a chosen word, so applying it at the write latency of zero blanks the wrong word. Further cases cover rejected mode keys, coinciding strobes, single-location writes beside full-length reads, and a full-row burst that runs past column 255.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;

    localparam int COL_W       = 8;
    localparam int DATA_W      = 16;
    localparam int KEY_W       = 12;
    localparam int MAX_CL      = 3;
    localparam int RD_MASK_LAT = 2;

    // key field positions decoded by the mode register
    localparam int KEY_BL_LSB = 0;
    localparam int KEY_IL_BIT = 3;
    localparam int KEY_CL_LSB = 4;
    localparam int KEY_SW_BIT = 9;

    typedef enum logic [2:0] {
        BL_1    = 3'b000,
        BL_2    = 3'b001,
        BL_4    = 3'b010,
        BL_8    = 3'b011,
        BL_PAGE = 3'b111
    } blen_e;

    typedef struct packed {
        logic [1:0] cas_lat;
        blen_e      blen;
        logic       interleave;
        logic       single_wr;
    } mode_t;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [COL_W-1:0] col;
    } beat_t;

    localparam mode_t MODE_RESET = '{cas_lat: 2'd3, blen: BL_1,
                                     interleave: 1'b0, single_wr: 1'b0};

    function automatic logic key_legal(input logic [KEY_W-1:0] key);
        logic [2:0] cl;
        logic [2:0] bl;
        cl = key[KEY_CL_LSB +: 3];
        bl = key[KEY_BL_LSB +: 3];
        return (cl inside {3'd1, 3'd2, 3'd3}) &&
               (bl inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    endfunction

    function automatic mode_t key_decode(input logic [KEY_W-1:0] key);
        mode_t m;
        m.cas_lat    = key[KEY_CL_LSB +: 2];
        m.blen       = blen_e'(key[KEY_BL_LSB +: 3]);
        m.interleave = key[KEY_IL_BIT];
        m.single_wr  = key[KEY_SW_BIT];
        return m;
    endfunction

    function automatic logic [COL_W-1:0] blen_mask(input blen_e b);
        case (b)
            BL_2:    return COL_W'(1);
            BL_4:    return COL_W'(3);
            BL_8:    return COL_W'(7);
            BL_PAGE: return '1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sdcol_mode_reg.sv
module sdcol_mode_reg
    import sdcol_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mrs_en,
    input  logic [KW-1:0] mrs_key,
    output mode_t         mode
);

    logic key_ok;
    assign key_ok = key_legal(KEY_W'(mrs_key));

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_RESET;
        else if (mrs_en && key_ok)
            mode <= key_decode(KEY_W'(mrs_key));
    end

    assert_bad_key_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (mrs_en && !key_ok) |=> $stable(mode));

    assert_latency_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        mrs_en |=> (mode.cas_lat != 2'd0));

endmodule

// File: rtl/sdcol_burst_gen.sv
module sdcol_burst_gen
    import sdcol_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic          rd_cmd,
    input  logic          wr_cmd,
    input  logic          pre_cmd,
    input  logic          bst_cmd,
    input  logic [CW-1:0] col_in,
    output beat_t         beat
);

    logic          kill, start_rd, start_wr, start;
    logic [CW-1:0] cmd_mask;
    logic          cmd_il, cmd_page;

    logic          act_q, wr_q, il_q, page_q;
    logic [CW-1:0] start_q, mask_q, cnt_q;
    logic [CW-1:0] off, cur_col;

    assign kill     = pre_cmd | bst_cmd;
    assign start_rd = rd_cmd & ~kill;
    assign start_wr = wr_cmd & ~rd_cmd & ~kill;
    assign start    = start_rd | start_wr;

    always_comb begin
        cmd_mask = CW'(blen_mask(mode.blen));
        if (start_wr && mode.single_wr)
            cmd_mask = '0;
        cmd_il   = mode.interleave && (mode.blen != BL_PAGE);
        cmd_page = (mode.blen == BL_PAGE) && !(start_wr && mode.single_wr);
    end

    // column of the running burst from the latched start and beat count
    always_comb begin
        off     = il_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
        cur_col = (start_q & ~mask_q) | (off & mask_q);
    end

    always_comb begin
        beat = '0;
        if (start) begin
            beat.valid = 1'b1;
            beat.write = start_wr;
            beat.col   = col_in;
        end else if (act_q && !kill) begin
            beat.valid = 1'b1;
            beat.write = wr_q;
            beat.col   = cur_col;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            il_q    <= 1'b0;
            page_q  <= 1'b0;
            start_q <= '0;
            mask_q  <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            act_q   <= (cmd_mask != '0);
            wr_q    <= start_wr;
            il_q    <= cmd_il;
            page_q  <= cmd_page;
            start_q <= col_in;
            mask_q  <= cmd_mask;
            cnt_q   <= CW'(1);
        end else if (kill) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            cnt_q <= cnt_q + CW'(1);
            if (!page_q && cnt_q == mask_q)
                act_q <= 1'b0;
        end
    end

    assert_page_step_R5: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && !start && page_q && $past(beat.valid))
        |-> (beat.col == CW'($past(beat.col) + CW'(1))));

    assert_stop_ends_R10: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!beat.valid || rd_cmd || wr_cmd));

    assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
        (start_wr && mode.single_wr) |=> (!beat.valid || start));

    assert_read_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && wr_cmd) |-> !beat.write);

endmodule

// File: rtl/sdcol_store.sv
module sdcol_store #(
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW/8-1:0]   we,
    input  logic [CW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    localparam int BYTES = DW / 8;
    localparam int DEPTH = 1 << CW;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++)
                    lane[i] <= 8'h00;
            end else if (we[b]) begin
                lane[addr] <= wdata[b*8 +: 8];
            end
        end

        assign rdata[b*8 +: 8] = lane[addr];

        assert_lane_written_R7: assert property (@(posedge clk) disable iff (rst)
            we[b] |=> (lane[$past(addr)] == $past(wdata[b*8 +: 8])));
    end

endmodule

// File: rtl/sdcol_rd_pipe.sv
module sdcol_rd_pipe #(
    parameter int DW       = 16,
    parameter int MAXL     = 3,
    parameter int MASK_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cas_lat,
    input  logic            rd_beat,
    input  logic [DW-1:0]   rd_word,
    input  logic [DW/8-1:0] dqm,
    output logic            rd_valid,
    output logic [DW-1:0]   dq_out,
    output logic [DW/8-1:0] dq_oe
);

    localparam int BYTES = DW / 8;
    localparam int TAP_W = (MAXL > 1) ? $clog2(MAXL) : 1;

    logic [MAXL-1:0]  vld_q;
    logic [DW-1:0]    dat_q [MAXL];
    logic [BYTES-1:0] msk_q [MASK_LAT];
    logic [TAP_W-1:0] tap;
    logic [DW-1:0]    tap_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < MAXL; i++)
                dat_q[i] <= '0;
            for (int i = 0; i < MASK_LAT; i++)
                msk_q[i] <= '0;
        end else begin
            vld_q[0] <= rd_beat;
            dat_q[0] <= rd_word;
            for (int i = 1; i < MAXL; i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
            msk_q[0] <= dqm;
            for (int i = 1; i < MASK_LAT; i++)
                msk_q[i] <= msk_q[i-1];
        end
    end

    assign tap      = TAP_W'(cas_lat - 2'd1);
    assign rd_valid = vld_q[tap];
    assign tap_word = dat_q[tap];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dq_oe[b]          = rd_valid & ~msk_q[MASK_LAT-1][b];
        assign dq_out[b*8 +: 8]  = dq_oe[b] ? tap_word[b*8 +: 8] : 8'h00;
    end

    if (MASK_LAT == 2) begin : g_mask_chk
        assert_read_mask_R9: assert property (@(posedge clk) disable iff (rst)
            rd_valid |-> ((dq_oe & $past(dqm, 2)) == '0));
    end

    assert_oe_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != '0) |-> rd_valid);

    assert_latency_one_R8: assert property (@(posedge clk) disable iff (rst)
        (cas_lat == 2'd1 && $past(rd_beat) && $stable(cas_lat)) |-> rd_valid);

endmodule

// File: rtl/sdram_col_engine.sv
module sdram_col_engine
    import sdcol_pkg::*;
#(
    parameter int CW   = COL_W,
    parameter int DW   = DATA_W,
    parameter int KW   = KEY_W,
    parameter int MAXL = MAX_CL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mrs_en,
    input  logic [KW-1:0]   mrs_key,
    input  logic            rd_cmd,
    input  logic            wr_cmd,
    input  logic            bst_cmd,
    input  logic            pre_cmd,
    input  logic [CW-1:0]   col_in,
    input  logic [DW/8-1:0] byte_mask,
    input  logic [DW-1:0]   wr_data,
    output logic            col_valid,
    output logic            col_wr,
    output logic [CW-1:0]   col_addr,
    output logic [DW/8-1:0] wr_be,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic [DW/8-1:0] rd_oe
);

    localparam int BYTES = DW / 8;

    mode_t         mode;
    beat_t         beat;
    logic [DW-1:0] store_q;
    logic          rd_beat;

    sdcol_mode_reg #(.KW(KW)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .mrs_en  (mrs_en),
        .mrs_key (mrs_key),
        .mode    (mode)
    );

    sdcol_burst_gen #(.CW(CW)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .rd_cmd  (rd_cmd),
        .wr_cmd  (wr_cmd),
        .pre_cmd (pre_cmd),
        .bst_cmd (bst_cmd),
        .col_in  (col_in),
        .beat    (beat)
    );

    assign col_valid = beat.valid;
    assign col_wr    = beat.write;
    assign col_addr  = beat.col;
    assign wr_be     = {BYTES{beat.valid & beat.write}} & ~byte_mask;
    assign rd_beat   = beat.valid & ~beat.write;

    sdcol_store #(.CW(CW), .DW(DW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_be),
        .addr  (beat.col),
        .wdata (wr_data),
        .rdata (store_q)
    );

    sdcol_rd_pipe #(.DW(DW), .MAXL(MAXL), .MASK_LAT(RD_MASK_LAT)) u_rdp (
        .clk      (clk),
        .rst      (rst),
        .cas_lat  (mode.cas_lat),
        .rd_beat  (rd_beat),
        .rd_word  (store_q),
        .dqm      (byte_mask),
        .rd_valid (rd_valid),
        .dq_out   (rd_data),
        .dq_oe    (rd_oe)
    );

    assert_wr_be_beat_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_be != '0) |-> (col_valid && col_wr));

endmodule

// File: tb/sdram_col_engine_tb.sv
`timescale 1ns/1ps
module sdram_col_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mrs_en = 1'b0;
    logic [11:0] mrs_key = '0;
    logic        rd_cmd = 1'b0, wr_cmd = 1'b0, bst_cmd = 1'b0, pre_cmd = 1'b0;
    logic [7:0]  col_in = '0;
    logic [1:0]  byte_mask = '0;
    logic [15:0] wr_data = '0;
    logic        col_valid, col_wr, rd_valid;
    logic [7:0]  col_addr;
    logic [1:0]  wr_be, rd_oe;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sdram_col_engine u_dut (
        .clk(clk), .rst(rst), .mrs_en(mrs_en), .mrs_key(mrs_key),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .bst_cmd(bst_cmd), .pre_cmd(pre_cmd),
        .col_in(col_in), .byte_mask(byte_mask), .wr_data(wr_data),
        .col_valid(col_valid), .col_wr(col_wr), .col_addr(col_addr),
        .wr_be(wr_be), .rd_valid(rd_valid), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    typedef struct packed {
        logic [2:0]  bl;
        logic        il;
        logic [3:0]  nb;
        logic [7:0]  start;
        logic [63:0] exp;
    } vec_t;

    // burst ordering table, latency 2; expected columns beat 0 first
    localparam vec_t VECS [8] = '{
        '{3'b010, 1'b0, 4'd4, 8'h05, 64'h0506070400000000},
        '{3'b010, 1'b1, 4'd4, 8'h05, 64'h0504070600000000},
        '{3'b011, 1'b0, 4'd8, 8'h1E, 64'h1E1F18191A1B1C1D},
        '{3'b011, 1'b1, 4'd8, 8'h1E, 64'h1E1F1C1D1A1B1819},
        '{3'b001, 1'b0, 4'd2, 8'h33, 64'h3332000000000000},
        '{3'b001, 1'b1, 4'd2, 8'h33, 64'h3332000000000000},
        '{3'b000, 1'b0, 4'd1, 8'h7F, 64'h7F00000000000000},
        '{3'b011, 1'b1, 4'd8, 8'h03, 64'h0302010007060504}
    };

    function automatic logic [11:0] mkkey(input logic [2:0] bl, input logic il,
                                          input logic [2:0] cl, input logic sw);
        return {2'b00, sw, 2'b00, cl, il, bl};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic pre, input logic bst,
                       input logic [7:0] col, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        mrs_en = 1'b0;
        rd_cmd = rd; wr_cmd = wr; pre_cmd = pre; bst_cmd = bst;
        col_in = col; wr_data = d; byte_mask = m;
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 2'b00);
    endtask

    task automatic mrs(input logic [11:0] k);
        @(negedge clk);
        mrs_en = 1'b1; mrs_key = k;
        rd_cmd = 1'b0; wr_cmd = 1'b0; pre_cmd = 1'b0; bst_cmd = 1'b0;
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        int bad;
        logic [15:0] exp4 [4];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        idle();
        check("R1", "col_valid", col_valid, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "rd_oe", rd_oe, 0);

        // R1/R3/R7 default single write
        cyc(0, 1, 0, 0, 8'h10, 16'hA5C3, 2'b00);
        check("R3", "write beat0 col", {col_valid, col_wr, col_addr}, {2'b11, 8'h10});
        check("R7", "write be", wr_be, 2'b11);
        idle();
        check("R1", "default length 1", col_valid, 0);

        // R1/R8 default latency 3
        cyc(1, 0, 0, 0, 8'h10, 0, 0);
        check("R12", "read not write", col_wr, 0);
        idle(); check("R8", "cl3 t+1", rd_valid, 0);
        idle(); check("R8", "cl3 t+2", rd_valid, 0);
        idle(); check("R8", "cl3 t+3 data", {rd_valid, rd_oe, rd_data}, {3'b111, 16'hA5C3});
        idle(); check("R8", "cl3 t+4", rd_valid, 0);

        // table of burst orderings, R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            mrs(mkkey(VECS[v].bl, VECS[v].il, 3'd2, 1'b0));
            cyc(1, 0, 0, 0, VECS[v].start, 0, 0);
            for (int k = 0; k < int'(VECS[v].nb); k++) begin
                if (k > 0) idle();
                check(VECS[v].il ? "R5" : "R4", "order beat col",
                      {col_valid, col_addr}, {1'b1, VECS[v].exp[63 - 8*k -: 8]});
            end
            idle();
            check("R3", "burst ends", col_valid, 0);
        end

        // R7 masked write burst, latency 1 length 4
        mrs(mkkey(3'b010, 1'b0, 3'd1, 1'b0));
        cyc(0, 1, 0, 0, 8'h20, 16'h1111, 2'b00);
        cyc(0, 0, 0, 0, 8'h00, 16'h2222, 2'b01);
        check("R7", "lower masked be", {col_addr, wr_be}, {8'h21, 2'b10});
        cyc(0, 0, 0, 0, 8'h00, 16'h3333, 2'b10);
        check("R7", "upper masked be", {col_addr, wr_be}, {8'h22, 2'b01});
        cyc(0, 0, 0, 0, 8'h00, 16'h4444, 2'b00);
        idle();
        check("R3", "four write beats", col_valid, 0);

        exp4 = '{16'h1111, 16'h2200, 16'h0033, 16'h4444};
        cyc(1, 0, 0, 0, 8'h20, 0, 0);
        for (int k = 0; k < 4; k++) begin
            idle();
            check("R7", "merged word cl1", {rd_valid, rd_oe, rd_data}, {3'b111, exp4[k]});
        end
        idle();
        check("R8", "cl1 end", rd_valid, 0);

        // R9 read mask two cycles ahead, latency 2
        mrs(mkkey(3'b010, 1'b0, 3'd2, 1'b0));
        cyc(1, 0, 0, 0, 8'h20, 0, 2'b00);
        cyc(0, 0, 0, 0, 8'h00, 0, 2'b00);
        cyc(0, 0, 0, 0, 8'h00, 0, 2'b01);
        check("R9", "beat0", {rd_valid, rd_oe, rd_data}, {3'b111, 16'h1111});
        idle();
        check("R9", "beat1", {rd_valid, rd_oe, rd_data}, {3'b111, 16'h2200});
        idle();
        check("R9", "beat2 lower off", {rd_valid, rd_oe, rd_data}, {3'b110, 16'h0000});
        idle();
        check("R9", "beat3", {rd_valid, rd_oe, rd_data}, {3'b111, 16'h4444});

        // R10 precharge during read, length 8 latency 2
        mrs(mkkey(3'b011, 1'b0, 3'd2, 1'b0));
        cyc(1, 0, 0, 0, 8'h20, 0, 0);
        idle();
        cyc(0, 0, 1, 0, 8'h00, 0, 0);
        check("R10", "no beat at precharge", col_valid, 0);
        check("R10", "data beat0", {rd_valid, rd_data}, {1'b1, 16'h1111});
        idle();
        check("R10", "data beat1", {col_valid, rd_valid, rd_data}, {2'b01, 16'h2200});
        idle();
        check("R10", "truncated", rd_valid, 0);

        // R10 burst stop on write
        cyc(0, 1, 0, 0, 8'h40, 16'h4000, 0);
        cyc(0, 0, 0, 0, 8'h00, 16'h4001, 0);
        cyc(0, 0, 0, 0, 8'h00, 16'h4002, 0);
        cyc(0, 0, 0, 1, 8'h00, 16'h4003, 0);
        check("R10", "stop no beat", {col_valid, wr_be}, 0);
        idle();
        cyc(1, 0, 0, 0, 8'h40, 0, 0);
        for (int k = 1; k <= 9; k++) begin
            idle();
            if (k >= 2 && k <= 5)
                check("R10", "stopped write contents", rd_data,
                      (k == 5) ? 16'h0000 : 16'h4000 + 16'(k - 2));
        end

        // R11 interrupting read
        cyc(1, 0, 0, 0, 8'h20, 0, 0);
        idle();
        cyc(1, 0, 0, 0, 8'h40, 0, 0);
        check("R11", "new start col", {col_valid, col_addr}, {1'b1, 8'h40});
        check("R11", "old beat0 data", rd_data, 16'h1111);
        bad = 0;
        for (int k = 1; k < 8; k++) begin
            idle();
            if (k == 1) check("R11", "old beat1 data", rd_data, 16'h2200);
            if (k == 2) check("R11", "new beat0 data", rd_data, 16'h4000);
            if (!(col_valid && col_addr == 8'h40 + 8'(k))) bad++;
        end
        check("R11", "new burst columns", bad, 0);
        idle();
        check("R11", "new burst ends", col_valid, 0);
        repeat (3) idle();

        // R12 coinciding strobes
        cyc(1, 0, 1, 0, 8'h20, 0, 0);
        check("R12", "read with precharge", col_valid, 0);
        idle();
        check("R12", "nothing started", col_valid, 0);
        cyc(1, 1, 0, 0, 8'h20, 16'hFFFF, 0);
        check("R12", "read beats write", {col_valid, col_wr, wr_be}, {2'b10, 2'b00});
        cyc(0, 1, 0, 1, 8'h30, 16'hFFFF, 0);
        check("R12", "stop beats write", {col_valid, wr_be}, 0);
        idle();
        check("R12", "after stop", col_valid, 0);
        repeat (3) idle();

        // R6 single-location writes
        mrs(mkkey(3'b010, 1'b0, 3'd2, 1'b1));
        cyc(0, 1, 0, 0, 8'h50, 16'h5555, 0);
        check("R6", "write beat", {col_valid, col_wr}, 2'b11);
        idle();
        check("R6", "single write only", col_valid, 0);
        cyc(1, 0, 0, 0, 8'h50, 0, 0);
        n = int'(col_valid);
        for (int t = 1; t <= 5; t++) begin
            idle();
            n += int'(col_valid);
            if (t == 2) check("R6", "written word", {rd_valid, rd_data}, {1'b1, 16'h5555});
        end
        check("R6", "read keeps length 4", n, 4);

        // R2 unsupported keys ignored
        mrs(mkkey(3'b011, 1'b0, 3'd0, 1'b0));
        mrs(mkkey(3'b100, 1'b0, 3'd1, 1'b0));
        cyc(1, 0, 0, 0, 8'h20, 0, 0);
        n = int'(col_valid);
        for (int t = 1; t <= 6; t++) begin
            idle();
            n += int'(col_valid);
            if (t == 1) check("R2", "latency kept t+1", rd_valid, 0);
            if (t == 2) check("R2", "latency kept t+2", {rd_valid, rd_data}, {1'b1, 16'h1111});
        end
        check("R2", "length kept", n, 4);

        // R5 full-row burst with interleave bit set stays sequential
        mrs(mkkey(3'b111, 1'b1, 3'd1, 1'b0));
        cyc(1, 0, 0, 0, 8'hFE, 0, 0);
        check("R5", "page start", {col_valid, col_addr}, {1'b1, 8'hFE});
        bad = 0;
        for (int k = 1; k < 260; k++) begin
            idle();
            if (!(col_valid && col_addr == 8'(8'hFE + k))) bad++;
        end
        check("R5", "page wrap columns", bad, 0);
        cyc(0, 0, 0, 1, 8'h00, 0, 0);
        check("R10", "page stop", col_valid, 0);
        idle();
        check("R5", "page ended", col_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule